// File: doc/BRIEF.md
# Multi-Lane Serial Flash Shifter

This block moves bytes between a pair of byte streams and a serial flash device over one, two or four bidirectional data lines. It makes the serial clock from the system clock through an even divider, with the idle level and the launch/sample phase chosen by two control pins. Bits can go out and come in with either the most or the least significant bit first. Up to four active-low chip-select outputs follow an enable mask for the length of each transfer.

Each transmit-stream beat holds one byte plus a direction flag. A write beat shifts the byte out. A read beat tri-states the active lines and shifts a byte in, which then appears on the receive stream. Both streams use valid/ready. The transmit side has a one-entry buffer, so `tx_ready` is high whenever that entry is empty. The receive side holds its byte, with `rx_data` steady, until `rx_ready` is seen high. A read beat does not start while a received byte is still waiting. Back-pressure on the receive side therefore stalls reads, and writes keep going.

When one or two lanes are in use, lines 2 and 3 are not needed for data. They are driven all the time with static write-protect and hold levels. A global enable and three flush requests (transmit buffer, receive buffer, transfer control) complete the control set.

Top module: `flash_lane_shifter`

## Requirements
- R1: `lane_sel` picks the lane count. 2'b00 uses line 0 only, 2'b01 uses lines 1..0, and 2'b10 uses lines 3..0. With 2'b11 no transfer starts and a pending beat stays buffered.
- R2: When the effective lane select is 2'b00 or 2'b01, `dq_oe[3:2]` is 2'b11 and `dq_o[3]`/`dq_o[2]` equal `hold_level`/`wp_level` at all times. With 2'b10 these two lines carry data, or are released when the block is idle.
- R3: Whenever no transfer is active, `sck` equals `cpol`: low when `cpol`=0, high when `cpol`=1.
- R4: With `cpha`=0, `sck` is still idle in the first cycle of the transfer and its first toggle comes mid-bit. With `cpha`=1, `sck` is already at its active level in the first cycle. Each transfer has exactly 2*(8/lanes) `sck` toggles.
- R5: On a write, the bits appear on the active lines. With `lsb_first`=0 the most significant bits go out first, and within a group the higher-order bit sits on the higher line. With `lsb_first`=1 the least significant bits go out first, and line j carries bit j of the group. All active lines have `dq_oe` set.
- R6: On a read, `dq_oe[1:0]` are 0 for the whole transfer and all active lines are tri-stated. Data is sampled on the `sck` edge opposite to the launch edge. The byte is reassembled using the same line and bit order as R5.
- R7: `cs_n` equals the bitwise inverse of `cs_mask` for the whole transfer and returns to 4'b1111 one system clock after the last bit. A mask of 0 asserts no select while `sck` still runs.
- R8: Each half period of `sck` lasts `half_div` system clocks. A value of 0 counts as 1, so the smallest divide is 2.
- R9: With `enable` low no transfer starts. An active transfer is dropped within one clock: `cs_n` goes to all ones and `sck` goes to idle.
- R10: A flush request acts once, on its rising edge, however long it is held. `tx_flush` discards the buffered beat, `rx_flush` drops a held received byte, and `ctl_flush` aborts the active transfer.
- R11: `tx_ready` is high exactly when the transmit entry is empty. A held received byte keeps `rx_valid` high and `rx_data` steady until `rx_ready`. While that byte is held, a read beat waits without starting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Global enable |
| lane_sel | input | 2 | Lane count select |
| cpol | input | 1 | Serial clock idle level |
| cpha | input | 1 | Serial clock phase |
| lsb_first | input | 1 | Bit order, 1 = LSB first |
| cs_mask | input | 4 | Chip-select enable mask |
| wp_level | input | 1 | Static level for line 2 in narrow modes |
| hold_level | input | 1 | Static level for line 3 in narrow modes |
| half_div | input | 8 | System clocks per sck half period |
| tx_flush | input | 1 | Transmit buffer flush request |
| rx_flush | input | 1 | Receive buffer flush request |
| ctl_flush | input | 1 | Transfer control flush request |
| tx_valid | input | 1 | Transmit beat valid |
| tx_ready | output | 1 | Transmit entry empty |
| tx_data | input | 8 | Byte to send |
| tx_read | input | 1 | Beat is a read transfer |
| rx_valid | output | 1 | Received byte valid |
| rx_ready | input | 1 | Receiver accepts byte |
| rx_data | output | 8 | Received byte |
| sck | output | 1 | Serial clock |
| cs_n | output | 4 | Active-low chip selects |
| dq_o | output | 4 | Data line output values |
| dq_oe | output | 4 | Data line output enables |
| dq_i | input | 4 | Data line input values |

## Verification
The hardest state to reach is a read that is stalled. A received byte must sit unclaimed while a second read beat is already buffered, so that the receive back-pressure, the read-start gate and the receive flush all meet in one place. The bench holds `rx_ready` low through a first read and then pushes a second read beat. It checks that neither a select nor a clock edge appears, and that the held byte stays steady. It then pulses `rx_flush` and checks that the blocked read starts at once. A mid-transfer abort is reached by setting a long half period, so the flush or the disable arrives while the select is still low.

// File: rtl/flash_shifter_pkg.sv
`timescale 1ns/1ps
package flash_shifter_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_DONE} xfer_state_e;

  localparam logic [1:0] LANE_X1   = 2'b00;
  localparam logic [1:0] LANE_X2   = 2'b01;
  localparam logic [1:0] LANE_X4   = 2'b10;
  localparam logic [1:0] LANE_RSVD = 2'b11;

  typedef struct packed {
    logic [1:0] lanes;
    logic       lsb;
    logic       cpol;
    logic       cpha;
    logic       rd;
    logic [3:0] cs;
  } xfer_ctl_t;

  function automatic logic [3:0] lane_mask(input logic [1:0] sel);
    case (sel)
      LANE_X1: return 4'b0001;
      LANE_X2: return 4'b0011;
      LANE_X4: return 4'b1111;
      default: return 4'b0000;
    endcase
  endfunction
endpackage

// File: rtl/fls_half_timer.sv
`timescale 1ns/1ps
module fls_half_timer #(
  parameter int DIV_W = 8,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] half_len,
  input  logic [IDX_W-1:0] last_idx,
  output logic [IDX_W-1:0] idx,
  output logic             half_end,
  output logic             last_end
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] lim;

  assign lim      = (half_len == '0) ? DIV_W'(1) : half_len;
  assign half_end = run && (cnt == lim - DIV_W'(1));
  assign last_end = half_end && (idx == last_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      idx <= '0;
    end else if (!run) begin
      cnt <= '0;
      idx <= '0;
    end else if (half_end) begin
      cnt <= '0;
      idx <= idx + IDX_W'(1);
    end else begin
      cnt <= cnt + DIV_W'(1);
    end
  end
endmodule

// File: rtl/fls_lane_mux.sv
`timescale 1ns/1ps
module fls_lane_mux
  import flash_shifter_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] sr,
  input  logic [1:0]   lanes,
  input  logic         lsb,
  input  logic [3:0]   dq_i,
  output logic [3:0]   out_bits,
  output logic [W-1:0] sr_shl,
  output logic [W-1:0] sr_ins
);
  always_comb begin
    case (lanes)
      LANE_X1: begin
        if (lsb) begin
          out_bits = {3'b000, sr[0]};
          sr_shl   = {1'b0, sr[W-1:1]};
          sr_ins   = {dq_i[0], sr[W-1:1]};
        end else begin
          out_bits = {3'b000, sr[W-1]};
          sr_shl   = {sr[W-2:0], 1'b0};
          sr_ins   = {sr[W-2:0], dq_i[0]};
        end
      end
      LANE_X2: begin
        if (lsb) begin
          out_bits = {2'b00, sr[1:0]};
          sr_shl   = {2'b00, sr[W-1:2]};
          sr_ins   = {dq_i[1:0], sr[W-1:2]};
        end else begin
          out_bits = {2'b00, sr[W-1:W-2]};
          sr_shl   = {sr[W-3:0], 2'b00};
          sr_ins   = {sr[W-3:0], dq_i[1:0]};
        end
      end
      default: begin
        if (lsb) begin
          out_bits = sr[3:0];
          sr_shl   = {4'b0000, sr[W-1:4]};
          sr_ins   = {dq_i, sr[W-1:4]};
        end else begin
          out_bits = sr[W-1:W-4];
          sr_shl   = {sr[W-5:0], 4'b0000};
          sr_ins   = {sr[W-5:0], dq_i};
        end
      end
    endcase
  end
endmodule

// File: rtl/flash_lane_shifter.sv
`timescale 1ns/1ps
module flash_lane_shifter
  import flash_shifter_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8,
  parameter int CS_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [1:0]        lane_sel,
  input  logic              cpol,
  input  logic              cpha,
  input  logic              lsb_first,
  input  logic [CS_W-1:0]   cs_mask,
  input  logic              wp_level,
  input  logic              hold_level,
  input  logic [DIV_W-1:0]  half_div,
  input  logic              tx_flush,
  input  logic              rx_flush,
  input  logic              ctl_flush,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_read,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [DATA_W-1:0] rx_data,
  output logic              sck,
  output logic [CS_W-1:0]   cs_n,
  output logic [3:0]        dq_o,
  output logic [3:0]        dq_oe,
  input  logic [3:0]        dq_i
);
  localparam int IDX_W = $clog2(2 * DATA_W);

  xfer_state_e       state;
  xfer_ctl_t         ctl;
  logic [DATA_W-1:0] sr, sr_shl, sr_ins, tb_data, rx_q;
  logic              tb_full, tb_read, rx_q_valid;
  logic [2:0]        req_q;
  logic              tx_clr, rx_clr, ctl_clr;
  logic              shifting, in_done, busy, rd_busy, start;
  logic              half_end, last_end;
  logic [IDX_W-1:0]  idx, last_idx;
  logic [3:0]        lane_bits;
  logic [1:0]        lanes_eff;
  logic              narrow, drive_data;

  // one-shot flush pulses
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= '0;
    else        req_q <= {ctl_flush, rx_flush, tx_flush};
  end
  assign tx_clr  = tx_flush  & ~req_q[0];
  assign rx_clr  = rx_flush  & ~req_q[1];
  assign ctl_clr = ctl_flush & ~req_q[2];

  assign shifting = (state == ST_SHIFT);
  assign in_done  = (state == ST_DONE);
  assign busy     = shifting | in_done;
  assign rd_busy  = busy & ctl.rd;

  assign start = (state == ST_IDLE) && enable && tb_full && !tx_clr && !ctl_clr &&
                 (lane_sel != LANE_RSVD) && !(tb_read && rx_q_valid);

  // transmit entry
  assign tx_ready = ~tb_full;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tb_full <= 1'b0;
      tb_data <= '0;
      tb_read <= 1'b0;
    end else if (tx_clr || start) begin
      tb_full <= 1'b0;
    end else if (tx_valid && tx_ready) begin
      tb_full <= 1'b1;
      tb_data <= tx_data;
      tb_read <= tx_read;
    end
  end

  always_comb begin
    case (ctl.lanes)
      LANE_X1: last_idx = IDX_W'(2 * DATA_W - 1);
      LANE_X2: last_idx = IDX_W'(DATA_W - 1);
      default: last_idx = IDX_W'(DATA_W / 2 - 1);
    endcase
  end

  fls_half_timer #(.DIV_W(DIV_W), .IDX_W(IDX_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(shifting), .half_len(half_div),
    .last_idx(last_idx), .idx(idx), .half_end(half_end), .last_end(last_end)
  );

  fls_lane_mux #(.W(DATA_W)) u_mux (
    .sr(sr), .lanes(ctl.lanes), .lsb(ctl.lsb), .dq_i(dq_i),
    .out_bits(lane_bits), .sr_shl(sr_shl), .sr_ins(sr_ins)
  );

  // transfer sequencing
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      ctl   <= '0;
      sr    <= '0;
    end else if (!enable || ctl_clr) begin
      state <= ST_IDLE;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          state     <= ST_SHIFT;
          sr        <= tb_data;
          ctl.lanes <= lane_sel;
          ctl.lsb   <= lsb_first;
          ctl.cpol  <= cpol;
          ctl.cpha  <= cpha;
          ctl.rd    <= tb_read;
          ctl.cs    <= cs_mask;
        end
        ST_SHIFT: begin
          if (last_end) state <= ST_DONE;
          else if (half_end) begin
            if (ctl.rd && !idx[0])      sr <= sr_ins;
            else if (!ctl.rd && idx[0]) sr <= sr_shl;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // receive entry
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q_valid <= 1'b0;
      rx_q       <= '0;
    end else if (rx_clr) begin
      rx_q_valid <= 1'b0;
    end else if (shifting && last_end && ctl.rd && enable && !ctl_clr) begin
      rx_q_valid <= 1'b1;
      rx_q       <= sr;
    end else if (rx_ready) begin
      rx_q_valid <= 1'b0;
    end
  end
  assign rx_valid = rx_q_valid;
  assign rx_data  = rx_q;

  // pins
  assign sck  = shifting ? (ctl.cpol ^ ctl.cpha ^ idx[0]) : (busy ? ctl.cpol : cpol);
  assign cs_n = busy ? ~ctl.cs : {CS_W{1'b1}};

  assign lanes_eff  = busy ? ctl.lanes : lane_sel;
  assign narrow     = (lanes_eff == LANE_X1) || (lanes_eff == LANE_X2);
  assign drive_data = shifting & ~rd_busy;
  assign dq_oe = (drive_data ? lane_mask(ctl.lanes) : 4'b0000) | (narrow ? 4'b1100 : 4'b0000);
  assign dq_o  = (drive_data ? (lane_bits & lane_mask(ctl.lanes)) : 4'b0000) |
                 (narrow ? {hold_level, wp_level, 2'b00} : 4'b0000);
endmodule

// File: rtl/fls_checker.sv
`timescale 1ns/1ps
module fls_checker #(
  parameter int DATA_W = 8,
  parameter int CS_W   = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              enable,
  input logic              cpol,
  input logic [1:0]        lane_sel,
  input logic              wp_level,
  input logic              hold_level,
  input logic              sck,
  input logic [CS_W-1:0]   cs_n,
  input logic [3:0]        dq_o,
  input logic [3:0]        dq_oe,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic              rx_flush,
  input logic [DATA_W-1:0] rx_data,
  input logic              busy,
  input logic              in_done,
  input logic              rd_busy
);
  AST_NARROW_STATIC: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !lane_sel[1]) |-> (dq_oe[3:2] == 2'b11 && dq_o[3:2] == {hold_level, wp_level})); // R2
  AST_IDLE_SCK: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sck == cpol)); // R3
  AST_READ_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_busy |-> (dq_oe[1:0] == 2'b00)); // R6
  AST_CS_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    in_done |=> (cs_n == {CS_W{1'b1}})); // R7
  AST_DISABLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!busy && cs_n == {CS_W{1'b1}})); // R9
  AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready && !rx_flush) |=> (rx_valid && $stable(rx_data))); // R11
endmodule

bind flash_lane_shifter fls_checker #(.DATA_W(DATA_W), .CS_W(CS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .cpol(cpol), .lane_sel(lane_sel),
  .wp_level(wp_level), .hold_level(hold_level), .sck(sck), .cs_n(cs_n),
  .dq_o(dq_o), .dq_oe(dq_oe), .rx_valid(rx_valid), .rx_ready(rx_ready),
  .rx_flush(rx_flush), .rx_data(rx_data), .busy(busy), .in_done(in_done),
  .rd_busy(rd_busy)
);

// File: tb/sim_flash_lane_shifter.sv
`timescale 1ns/1ps
module sim_flash_lane_shifter;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic [1:0] lane_sel = 2'b00;
  logic cpol = 1'b0, cpha = 1'b0, lsb_first = 1'b0;
  logic [3:0] cs_mask = 4'b0001;
  logic wp_level = 1'b1, hold_level = 1'b0;
  logic [7:0] half_div = 8'd1;
  logic tx_flush = 1'b0, rx_flush = 1'b0, ctl_flush = 1'b0;
  logic tx_valid = 1'b0, tx_read = 1'b0, rx_ready = 1'b1;
  logic [7:0] tx_data = 8'h00;
  logic tx_ready, rx_valid, sck;
  logic [7:0] rx_data;
  logic [3:0] cs_n, dq_o, dq_oe;
  logic [3:0] dq_i = 4'h0;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  flash_lane_shifter u0 (
    .clk(clk), .rst_n(rst_n), .enable(enable), .lane_sel(lane_sel), .cpol(cpol),
    .cpha(cpha), .lsb_first(lsb_first), .cs_mask(cs_mask), .wp_level(wp_level),
    .hold_level(hold_level), .half_div(half_div), .tx_flush(tx_flush),
    .rx_flush(rx_flush), .ctl_flush(ctl_flush), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .tx_read(tx_read), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .rx_data(rx_data), .sck(sck), .cs_n(cs_n), .dq_o(dq_o),
    .dq_oe(dq_oe), .dq_i(dq_i)
  );

  typedef struct packed {
    logic [1:0] lanes;
    logic       lsb;
    logic       pol;
    logic       pha;
    logic       rd;
    logic [7:0] data;
    logic [7:0] half;
    logic [3:0] mask;
  } vec_t;

  localparam vec_t VECS [10] = '{
    '{2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 8'hA5, 8'd1, 4'b0001},
    '{2'b00, 1'b1, 1'b1, 1'b1, 1'b0, 8'h3C, 8'd2, 4'b0010},
    '{2'b01, 1'b0, 1'b0, 1'b1, 1'b0, 8'hB2, 8'd1, 4'b0100},
    '{2'b01, 1'b1, 1'b1, 1'b0, 1'b0, 8'h6D, 8'd3, 4'b1001},
    '{2'b10, 1'b0, 1'b0, 1'b0, 1'b0, 8'hE7, 8'd2, 4'b1000},
    '{2'b10, 1'b1, 1'b1, 1'b1, 1'b0, 8'h1F, 8'd0, 4'b1111},
    '{2'b00, 1'b0, 1'b0, 1'b0, 1'b1, 8'hC9, 8'd2, 4'b0001},
    '{2'b01, 1'b1, 1'b1, 1'b1, 1'b1, 8'h5A, 8'd1, 4'b0011},
    '{2'b10, 1'b0, 1'b0, 1'b1, 1'b1, 8'h96, 8'd3, 4'b0110},
    '{2'b10, 1'b1, 1'b0, 1'b0, 1'b1, 8'h2B, 8'd1, 4'b1010}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] d, input logic rd);
    tx_data = d; tx_read = rd; tx_valid = 1'b1;
    for (int i = 0; i < 1000 && !tx_ready; i++) @(negedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic run_vec(input vec_t v);
    int lanes, cells, h, cs_cnt, edges, samp, last_t, bad_iv, bad_dat, bad_oe, bad_cs;
    bit seen, phase_ok;
    logic prev;
    logic [3:0] expc [8];
    logic [3:0] lm;
    lanes = (v.lanes == 2'b00) ? 1 : (v.lanes == 2'b01) ? 2 : 4;
    cells = 8 / lanes;
    h = (v.half == 0) ? 1 : int'(v.half);
    lm = (lanes == 1) ? 4'b0001 : (lanes == 2) ? 4'b0011 : 4'b1111;
    for (int k = 0; k < 8; k++) begin
      expc[k] = 4'h0;
      if (k < cells)
        for (int j = 0; j < lanes; j++)
          expc[k][j] = v.lsb ? v.data[k*lanes + j] : v.data[8 - (k+1)*lanes + j];
    end
    lane_sel = v.lanes; lsb_first = v.lsb; cpol = v.pol; cpha = v.pha;
    half_div = v.half; cs_mask = v.mask; rx_ready = 1'b0;
    dq_i = v.rd ? expc[0] : 4'h0;
    @(negedge clk);
    push(v.data, v.rd);
    cs_cnt = 0; edges = 0; samp = 0; last_t = -1;
    bad_iv = 0; bad_dat = 0; bad_oe = 0; bad_cs = 0;
    seen = 1'b0; phase_ok = 1'b1; prev = sck;
    for (int t = 0; t < 4000; t++) begin
      if (cs_n != 4'hF) begin
        if (!seen) phase_ok = (sck == (v.pol ^ v.pha));
        seen = 1'b1;
        cs_cnt++;
        if (~cs_n != v.mask) bad_cs++;
      end else if (seen) begin
        break;
      end
      if (sck != prev) begin
        if (last_t >= 0 && (t - last_t) != h) bad_iv++;
        last_t = t;
        if (sck == (v.pha ? v.pol : ~v.pol)) begin
          if (!v.rd) begin
            if ((dq_o & lm) != expc[samp]) bad_dat++;
            if ((dq_oe & lm) != lm) bad_oe++;
          end else begin
            if ((dq_oe & lm) != 4'h0) bad_oe++;
            if (samp + 1 < cells) dq_i = expc[samp + 1];
          end
          samp++;
        end
        edges++;
      end
      prev = sck;
      @(negedge clk);
    end
    check(phase_ok, "R4 first-cycle sck phase", sck, v.pol ^ v.pha);
    check(edges == 2*cells, "R4 sck toggle count", edges, 2*cells);
    check(bad_iv == 0, "R8 half period length", bad_iv, 0);
    check(cs_cnt == 2*cells*h + 1, "R7 select low duration", cs_cnt, 2*cells*h + 1);
    check(bad_cs == 0, "R7 select pattern", bad_cs, 0);
    if (!v.rd) begin
      check(bad_dat == 0, "R5 lane bit order", bad_dat, 0);
      check(bad_oe == 0, "R5 active lane enables", bad_oe, 0);
    end else begin
      check(bad_oe == 0, "R6 lines tri-stated on read", bad_oe, 0);
      check(rx_valid && rx_data == v.data, "R6 received byte", rx_data, v.data);
      rx_ready = 1'b1;
      @(negedge clk);
    end
    check(v.lanes[1] || (dq_oe[3:2] == 2'b11 && dq_o[3:2] == {hold_level, wp_level}),
          "R2 static lines after transfer", dq_o, {hold_level, wp_level, 2'b00});
    rx_ready = 1'b1;
  endtask

  task automatic count_window(input int n, output int lows, output int toggles);
    logic p;
    lows = 0; toggles = 0; p = sck;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (cs_n != 4'hF) lows++;
      if (sck != p) toggles++;
      p = sck;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int lows, tog, t;
    repeat (3) @(negedge clk);
    // reset state
    check(cs_n == 4'hF && sck == 1'b0, "R3 reset idle outputs", {cs_n, 3'b0, sck}, 8'hF0);
    check(tx_ready && !rx_valid, "R11 reset stream state", {tx_ready, rx_valid}, 2'b10);
    check(dq_oe == 4'b1100 && dq_o == 4'b0100, "R2 static levels in reset", {dq_oe, dq_o}, 8'hC4);
    rst_n = 1'b1; enable = 1'b1;
    @(negedge clk);

    // R2 dual and quad idle
    lane_sel = 2'b01; wp_level = 1'b0; hold_level = 1'b1;
    @(negedge clk);
    check(dq_oe[3:2] == 2'b11 && dq_o[3:2] == 2'b10, "R2 dual-mode static lines", dq_o, 4'b1000);
    lane_sel = 2'b10;
    @(negedge clk);
    check(dq_oe == 4'b0000, "R2 quad-mode idle release", dq_oe, 0);
    cpol = 1'b1;
    @(negedge clk);
    check(sck == 1'b1, "R3 idle high with cpol set", sck, 1);
    cpol = 1'b0;

    // vector table
    foreach (VECS[i]) run_vec(VECS[i]);

    // R1 reserved lane select keeps the beat pending
    lane_sel = 2'b11; cpol = 1'b0; half_div = 8'd1; cs_mask = 4'b0001;
    push(8'h55, 1'b0);
    count_window(20, lows, tog);
    check(lows == 0 && tog == 0, "R1 reserved select starts nothing", lows + tog, 0);
    check(!tx_ready, "R1 beat stays buffered", tx_ready, 0);
    // R10 tx flush, held for several cycles
    tx_flush = 1'b1;
    repeat (3) @(negedge clk);
    check(tx_ready, "R10 tx flush empties entry", tx_ready, 1);
    lane_sel = 2'b00;
    count_window(20, lows, tog);
    check(lows == 0, "R10 flushed beat never sent", lows, 0);
    tx_flush = 1'b0;

    // R9 disabled: beat waits
    enable = 1'b0;
    push(8'h81, 1'b0);
    count_window(20, lows, tog);
    check(lows == 0 && tog == 0, "R9 no transfer while disabled", lows + tog, 0);
    enable = 1'b1;
    count_window(40, lows, tog);
    check(lows == 2*8*1 + 1, "R9 pending beat runs once enabled", lows, 17);
    // R9 abort mid-transfer
    half_div = 8'd8;
    push(8'h42, 1'b0);
    for (t = 0; t < 50 && cs_n == 4'hF; t++) @(negedge clk);
    repeat (5) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    check(cs_n == 4'hF && sck == cpol, "R9 abort on disable", cs_n, 4'hF);
    enable = 1'b1;

    // R10 control flush aborts once, held high
    lane_sel = 2'b10;
    push(8'h77, 1'b0);
    for (t = 0; t < 50 && cs_n == 4'hF; t++) @(negedge clk);
    repeat (3) @(negedge clk);
    ctl_flush = 1'b1;
    @(negedge clk);
    check(cs_n == 4'hF, "R10 control flush aborts", cs_n, 4'hF);
    push(8'h78, 1'b0);
    count_window(60, lows, tog);
    check(lows == 2*2*8 + 1, "R10 held control flush acts once", lows, 33);
    ctl_flush = 1'b0;

    // R11 receive back-pressure stalls reads
    half_div = 8'd1; rx_ready = 1'b0; dq_i = 4'h9;
    push(8'h00, 1'b1);
    count_window(10, lows, tog);
    check(rx_valid && rx_data == 8'h99, "R11 first read held", rx_data, 8'h99);
    push(8'h00, 1'b1);
    count_window(30, lows, tog);
    check(lows == 0 && tog == 0, "R11 read waits while byte held", lows + tog, 0);
    check(rx_valid && rx_data == 8'h99, "R11 held byte steady", rx_data, 8'h99);
    rx_flush = 1'b1;
    @(negedge clk);
    check(!rx_valid, "R10 rx flush drops byte", rx_valid, 0);
    rx_flush = 1'b0;
    count_window(10, lows, tog);
    check(lows == 5, "R11 stalled read starts after flush", lows, 5);
    rx_ready = 1'b1;
    @(negedge clk);

    // R7 empty mask: clock runs, no select
    cs_mask = 4'b0000;
    push(8'hF0, 1'b0);
    count_window(20, lows, tog);
    check(lows == 0 && tog == 4, "R7 empty mask selects nothing", tog, 4);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule